// File: doc/BRIEF.md
# Packet-Mode I2C Request Sequencer

This block sits between software and a byte-level I2C engine. Software writes request packets into a 32-bit transmit queue. Each packet is three header words followed by payload words. The sequencer reads the headers and issues one byte command at a time to the engine: an address byte first, then one payload byte per command. For reads, it packs the returned bytes into 32-bit words and places them in a receive queue. Bit timing on the wires is left entirely to the engine.

A packet closes its transfer in one of three ways, chosen by two flags in its third header word:
- with a STOP;
- with the bus held, so that the next packet opens with a repeated START;
- with a continuation, where the next packet's bytes follow on with no START and no address byte.

Software tracks progress through the free-slot count of the transmit queue and the fill count of the receive queue. Failures appear as four sticky error flags. After any error the sequencer stops, discards what is queued and waits for reset.

Header layout used throughout:
- Word 0: bits [7:4] give the protocol type; the value 1 means I2C. Other bits are ignored.
- Word 1: bits [11:0] give the payload byte count minus one.
- Word 2:
  - bits [7:0]: the address byte, already formed as address shifted left by one plus the direction bit;
  - bit 8: 7-bit address mode (accepted, not acted on);
  - bit 9: read;
  - bit 10: hold the bus for a repeated START;
  - bit 11: continue into the next packet.

Top module: `i2c_pkt_seq`

## Requirements
- R1: After reset, tx_free equals TX_DEPTH (8), rx_count is 0, cmd_valid and busy are low, and all error flags are low.
- R2: Each tx_wr_en pulse with free space lowers tx_free by one once the word is stored; a write while tx_free is 0 is dropped and tx_free stays 0.
- R3: A packet whose word 0 bits [7:4] are not 1 sets err_proto and issues no command.
- R4: Unless a continuation is pending, the first command of a packet has cmd_start=1, cmd_read=0, cmd_stop=0 and cmd_byte equal to word 2 bits [7:0]; a command is held stable while cmd_ready is low.
- R5: A packet carries word 1 bits [11:0] plus one payload bytes. Write bytes are taken four per payload word, least significant byte first, and the unused upper bytes of the final word are ignored.
- R6: cmd_stop is set only on the last payload byte, and only when word 2 bits 10 and 11 are both clear. With bit 10 set there is no STOP, and the next packet's first command has cmd_start=1.
- R7: With word 2 bit 11 set, the next packet issues no address command, and none of its commands has cmd_start set.
- R8: Read commands carry cmd_nack=1 only on the last byte of a packet whose bit 11 is clear; every other read byte has cmd_nack=0.
- R9: Read bytes are packed least significant byte first. A word is pushed to the receive queue after four bytes, or at the end of the payload with the unfilled upper bytes zero.
- R10: A packet with word 2 bits 10 and 11 both set sets err_proto and issues no command.
- R11: A NACK on the address byte sets err_addr_nack and no further command is issued. The transmit queue is emptied (tx_free returns to 8), and later writes are dropped until reset.
- R12: A NACK on a written payload byte sets err_data_nack and no further command is issued.
- R13: An arbitration-lost response sets err_arb_lost, which stays set until reset; no further command is issued and no partial read word is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also the recovery after an error |
| tx_wr_en | input | 1 | Write one word into the transmit queue |
| tx_wr_data | input | 32 | Header or payload word |
| tx_free | output | 4 | Free transmit queue entries |
| rx_rd_en | input | 1 | Remove the head word of the receive queue |
| rx_rd_data | output | 32 | Head word of the receive queue |
| rx_count | output | 4 | Filled receive queue entries |
| cmd_valid | output | 1 | Byte command offered to the engine |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_start | output | 1 | Generate START or repeated START before this byte |
| cmd_read | output | 1 | 1 = receive a byte, 0 = send cmd_byte |
| cmd_byte | output | 8 | Byte to send |
| cmd_nack | output | 1 | Answer the received byte with NACK |
| cmd_stop | output | 1 | Generate STOP after this byte |
| rsp_valid | input | 1 | Engine finished the accepted command |
| rsp_byte | input | 8 | Received byte |
| rsp_nack | input | 1 | Target did not acknowledge the sent byte |
| rsp_arb | input | 1 | Arbitration was lost |
| err_proto | output | 1 | Sticky: malformed header |
| err_addr_nack | output | 1 | Sticky: address not acknowledged |
| err_data_nack | output | 1 | Sticky: data not acknowledged |
| err_arb_lost | output | 1 | Sticky: arbitration lost |
| busy | output | 1 | A packet is past its first header word and not finished |

## Verification
The assertions assume the engine answers with exactly one rsp_valid pulse for each accepted command, never before acceptance and never twice. They also assume rx_rd_en is raised only when rx_count is non-zero. The bench engine model meets both conditions: it logs each command on the cycle it is accepted and answers on the following cycle. The bench pops the receive queue only after it has checked rx_count. Error responses are injected only at a chosen command index, so each error path is reached from a known command count.

// File: rtl/i2c_pkt_pkg.sv
package i2c_pkt_pkg;
  localparam int PROTO_LSB = 4;
  localparam int PROTO_W   = 4;
  localparam int PROTO_I2C = 1;
  localparam int ABYTE_LSB = 0;
  localparam int RD_BIT    = 9;
  localparam int RS_BIT    = 10;
  localparam int CONT_BIT  = 11;

  typedef enum logic [2:0] {
    ST_HDR0, ST_HDR1, ST_HDR2, ST_PREP, ST_ISSUE, ST_WAIT, ST_ERR
  } seq_state_e;
endpackage

// File: rtl/i2c_pkt_fifo.sv
module i2c_pkt_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         wr_en,
  input  logic [DW-1:0]                wr_data,
  input  logic                         rd_en,
  output logic [DW-1:0]                rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_wr, do_rd;

  assign do_wr   = wr_en && (count != CW'(DEPTH)) && !flush;
  assign do_rd   = rd_en && (count != '0) && !flush;
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) rptr <= rptr + 1'b1;
      count <= count + CW'(do_wr) - CW'(do_rd);
    end
  end

  // R2: a write into a full queue must not change the count
  p_full_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && count == CW'(DEPTH) && !rd_en && !flush) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/i2c_pkt_ctrl.sv
module i2c_pkt_ctrl
  import i2c_pkt_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tx_empty,
  input  logic [31:0] tx_head,
  input  logic        rx_full,
  output logic        tx_pop,
  output logic        tx_flush,
  output logic        rx_push,
  output logic [31:0] rx_wdata,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic        cmd_start,
  output logic        cmd_read,
  output logic [7:0]  cmd_byte,
  output logic        cmd_nack,
  output logic        cmd_stop,
  input  logic        rsp_valid,
  input  logic [7:0]  rsp_byte,
  input  logic        rsp_nack,
  input  logic        rsp_arb,
  output logic        err_proto,
  output logic        err_addr,
  output logic        err_data,
  output logic        err_arb,
  output logic        busy
);
  seq_state_e       state;
  logic [LEN_W-1:0] len, idx;
  logic             rd_dir, f_rs, f_cont, cont_pend, in_addr;
  logic [7:0]       addr_byte;
  logic [31:0]      wbuf, rxbuf, packed_word;
  logic [1:0]       lane;
  logic             last, end_stop, end_nack;

  assign lane        = idx[1:0];
  assign last        = (idx == len);
  assign end_stop    = last && !f_rs && !f_cont;
  assign end_nack    = last && !f_cont;
  assign packed_word = rxbuf | ({24'b0, rsp_byte} << {lane, 3'b000});
  assign busy        = (state != ST_HDR0) && (state != ST_ERR);
  assign tx_flush    = (state == ST_ERR);
  assign rx_wdata    = packed_word;

  always_comb begin
    tx_pop = 1'b0;
    case (state)
      ST_HDR0, ST_HDR1, ST_HDR2: tx_pop = !tx_empty;
      ST_PREP: tx_pop = !in_addr && !rd_dir && (lane == 2'd0) && !tx_empty;
      default: tx_pop = 1'b0;
    endcase
  end

  assign rx_push = (state == ST_WAIT) && rsp_valid && !rsp_arb && rd_dir &&
                   !in_addr && ((lane == 2'd3) || last);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_HDR0;
      len       <= '0;
      idx       <= '0;
      rd_dir    <= 1'b0;
      f_rs      <= 1'b0;
      f_cont    <= 1'b0;
      cont_pend <= 1'b0;
      in_addr   <= 1'b0;
      addr_byte <= '0;
      wbuf      <= '0;
      rxbuf     <= '0;
      cmd_valid <= 1'b0;
      cmd_start <= 1'b0;
      cmd_read  <= 1'b0;
      cmd_byte  <= '0;
      cmd_nack  <= 1'b0;
      cmd_stop  <= 1'b0;
      err_proto <= 1'b0;
      err_addr  <= 1'b0;
      err_data  <= 1'b0;
      err_arb   <= 1'b0;
    end else begin
      case (state)
        ST_HDR0: if (!tx_empty) begin
          if (tx_head[PROTO_LSB +: PROTO_W] != PROTO_W'(PROTO_I2C)) begin
            err_proto <= 1'b1;
            state     <= ST_ERR;
          end else begin
            state <= ST_HDR1;
          end
        end
        ST_HDR1: if (!tx_empty) begin
          len   <= tx_head[LEN_W-1:0];
          state <= ST_HDR2;
        end
        ST_HDR2: if (!tx_empty) begin
          rd_dir    <= tx_head[RD_BIT];
          f_rs      <= tx_head[RS_BIT];
          f_cont    <= tx_head[CONT_BIT];
          addr_byte <= tx_head[ABYTE_LSB +: 8];
          idx       <= '0;
          rxbuf     <= '0;
          in_addr   <= !cont_pend;
          if (tx_head[RS_BIT] && tx_head[CONT_BIT]) begin
            err_proto <= 1'b1;
            state     <= ST_ERR;
          end else begin
            state <= ST_PREP;
          end
        end
        ST_PREP: begin
          if (in_addr) begin
            cmd_start <= 1'b1;
            cmd_read  <= 1'b0;
            cmd_byte  <= addr_byte;
            cmd_nack  <= 1'b0;
            cmd_stop  <= 1'b0;
            cmd_valid <= 1'b1;
            state     <= ST_ISSUE;
          end else if (rd_dir) begin
            if (!rx_full) begin
              cmd_start <= 1'b0;
              cmd_read  <= 1'b1;
              cmd_byte  <= '0;
              cmd_nack  <= end_nack;
              cmd_stop  <= end_stop;
              cmd_valid <= 1'b1;
              state     <= ST_ISSUE;
            end
          end else if (lane != 2'd0 || !tx_empty) begin
            if (lane == 2'd0) begin
              wbuf     <= tx_head;
              cmd_byte <= tx_head[7:0];
            end else begin
              cmd_byte <= wbuf[{lane, 3'b000} +: 8];
            end
            cmd_start <= 1'b0;
            cmd_read  <= 1'b0;
            cmd_nack  <= 1'b0;
            cmd_stop  <= end_stop;
            cmd_valid <= 1'b1;
            state     <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (cmd_ready) begin
          cmd_valid <= 1'b0;
          state     <= ST_WAIT;
        end
        ST_WAIT: if (rsp_valid) begin
          if (rsp_arb) begin
            err_arb <= 1'b1;
            state   <= ST_ERR;
          end else if (in_addr) begin
            if (rsp_nack) begin
              err_addr <= 1'b1;
              state    <= ST_ERR;
            end else begin
              in_addr <= 1'b0;
              state   <= ST_PREP;
            end
          end else if (!rd_dir && rsp_nack) begin
            err_data <= 1'b1;
            state    <= ST_ERR;
          end else begin
            if (rd_dir) rxbuf <= rx_push ? 32'b0 : packed_word;
            if (last) begin
              cont_pend <= f_cont;
              state     <= ST_HDR0;
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_PREP;
            end
          end
        end
        default: state <= ST_ERR;
      endcase
    end
  end

  // R4: an offered command holds until accepted
  p_cmd_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_byte) && $stable(cmd_start)));
  // R4: a START command always sends the address byte
  p_start_is_write_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_start) |-> !cmd_read);
  // R6: the address byte never carries a STOP
  p_stop_not_addr_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_start) |-> !cmd_stop);
  // R8: NACK is only answered on received bytes
  p_nack_read_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_nack) |-> cmd_read);
  // R11: once an error is flagged nothing is offered
  p_err_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (err_proto || err_addr || err_data || err_arb) |-> !cmd_valid);
  // R13: arbitration loss is sticky
  p_arb_sticky_r13: assert property (@(posedge clk) disable iff (rst)
    err_arb |=> err_arb);
endmodule

// File: rtl/i2c_pkt_seq.sv
module i2c_pkt_seq #(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  parameter int LEN_W    = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          tx_wr_en,
  input  logic [31:0]                   tx_wr_data,
  output logic [$clog2(TX_DEPTH+1)-1:0] tx_free,
  input  logic                          rx_rd_en,
  output logic [31:0]                   rx_rd_data,
  output logic [$clog2(RX_DEPTH+1)-1:0] rx_count,
  output logic                          cmd_valid,
  input  logic                          cmd_ready,
  output logic                          cmd_start,
  output logic                          cmd_read,
  output logic [7:0]                    cmd_byte,
  output logic                          cmd_nack,
  output logic                          cmd_stop,
  input  logic                          rsp_valid,
  input  logic [7:0]                    rsp_byte,
  input  logic                          rsp_nack,
  input  logic                          rsp_arb,
  output logic                          err_proto,
  output logic                          err_addr_nack,
  output logic                          err_data_nack,
  output logic                          err_arb_lost,
  output logic                          busy
);
  localparam int TXCW = $clog2(TX_DEPTH+1);
  localparam int RXCW = $clog2(RX_DEPTH+1);

  logic [TXCW-1:0] tx_count;
  logic [31:0]     tx_head, rx_wdata;
  logic            tx_pop, tx_flush, rx_push;

  assign tx_free = TXCW'(TX_DEPTH) - tx_count;

  i2c_pkt_fifo #(.DW(32), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .wr_en(tx_wr_en), .wr_data(tx_wr_data),
    .rd_en(tx_pop), .rd_data(tx_head), .count(tx_count));

  i2c_pkt_fifo #(.DW(32), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(1'b0),
    .wr_en(rx_push), .wr_data(rx_wdata),
    .rd_en(rx_rd_en), .rd_data(rx_rd_data), .count(rx_count));

  i2c_pkt_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .tx_empty(tx_count == '0), .tx_head(tx_head),
    .rx_full(rx_count == RXCW'(RX_DEPTH)),
    .tx_pop(tx_pop), .tx_flush(tx_flush),
    .rx_push(rx_push), .rx_wdata(rx_wdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_start(cmd_start),
    .cmd_read(cmd_read), .cmd_byte(cmd_byte), .cmd_nack(cmd_nack),
    .cmd_stop(cmd_stop),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .rsp_nack(rsp_nack),
    .rsp_arb(rsp_arb),
    .err_proto(err_proto), .err_addr(err_addr_nack), .err_data(err_data_nack),
    .err_arb(err_arb_lost), .busy(busy));
endmodule

// File: tb/i2c_pkt_seq_bench.sv
module i2c_pkt_seq_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_wr_en = 1'b0;
  logic [31:0] tx_wr_data = '0;
  logic [3:0] tx_free, rx_count;
  logic rx_rd_en = 1'b0;
  logic [31:0] rx_rd_data;
  logic cmd_valid, cmd_start, cmd_read, cmd_nack, cmd_stop;
  logic [7:0] cmd_byte;
  logic cmd_ready = 1'b1;
  logic rsp_valid = 1'b0, rsp_nack = 1'b0, rsp_arb = 1'b0;
  logic [7:0] rsp_byte = '0;
  logic err_proto, err_addr_nack, err_data_nack, err_arb_lost, busy;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  i2c_pkt_seq u_i2c_pkt_seq (
    .clk(clk), .rst(rst), .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data),
    .tx_free(tx_free), .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data),
    .rx_count(rx_count), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_start(cmd_start), .cmd_read(cmd_read), .cmd_byte(cmd_byte),
    .cmd_nack(cmd_nack), .cmd_stop(cmd_stop), .rsp_valid(rsp_valid),
    .rsp_byte(rsp_byte), .rsp_nack(rsp_nack), .rsp_arb(rsp_arb),
    .err_proto(err_proto), .err_addr_nack(err_addr_nack),
    .err_data_nack(err_data_nack), .err_arb_lost(err_arb_lost), .busy(busy));

  // engine model: logs each accepted command, answers one cycle later
  int   cmd_cnt = 0;
  int   nack_at = -1;
  int   arb_at  = -1;
  logic log_start [256];
  logic log_read  [256];
  logic log_nack  [256];
  logic log_stop  [256];
  logic [7:0] log_byte [256];

  function automatic logic [7:0] rbyte(int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  initial begin
    int pend;
    pend = -1;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0; rsp_nack = 1'b0; rsp_arb = 1'b0;
      if (pend >= 0) begin
        rsp_valid = 1'b1;
        rsp_nack  = (pend == nack_at);
        rsp_arb   = (pend == arb_at);
        rsp_byte  = rbyte(pend);
        pend = -1;
      end
      if (cmd_valid && cmd_ready && !rst) begin
        log_start[cmd_cnt & 255] = cmd_start;
        log_read[cmd_cnt & 255]  = cmd_read;
        log_nack[cmd_cnt & 255]  = cmd_nack;
        log_stop[cmd_cnt & 255]  = cmd_stop;
        log_byte[cmd_cnt & 255]  = cmd_byte;
        pend = cmd_cnt;
        cmd_cnt = cmd_cnt + 1;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; cmd_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic push(logic [31:0] w);
    @(negedge clk); tx_wr_en = 1'b1; tx_wr_data = w;
    @(negedge clk); tx_wr_en = 1'b0;
  endtask

  task automatic pop_rx(output logic [31:0] w);
    @(negedge clk); w = rx_rd_data; rx_rd_en = 1'b1;
    @(negedge clk); rx_rd_en = 1'b0;
  endtask

  function automatic logic [31:0] h0(int proto);
    return 32'h0001_0000 | 32'((proto & 15) << 4);
  endfunction
  function automatic logic [31:0] h2(logic [7:0] ab, bit rd, bit rs, bit ct);
    return 32'h100 | {24'b0, ab} | (32'(rd) << 9) | (32'(rs) << 10) | (32'(ct) << 11);
  endfunction

  task automatic settle();
    repeat (150) @(negedge clk);
  endtask

  task automatic t_reset_r1();
    do_reset();
    check("R1 tx_free", tx_free, 8);
    check("R1 rx_count", rx_count, 0);
    check("R1 cmd_valid", cmd_valid, 0);
    check("R1 busy", busy, 0);
    check("R1 errors", {err_proto, err_addr_nack, err_data_nack, err_arb_lost}, 0);
  endtask

  task automatic t_fill_r2();
    do_reset();
    cmd_ready = 1'b0;
    push(h0(1)); push(32'd0); push(h2(8'hA0, 0, 0, 0));
    repeat (4) @(negedge clk);
    check("R2 headers consumed", tx_free, 8);
    push(32'h11);
    check("R2 one word stored", tx_free, 7);
    for (int i = 0; i < 8; i++) push(32'h22);
    check("R2 full, extra dropped", tx_free, 0);
    do_reset();
  endtask

  task automatic t_write_r4();
    int b;
    do_reset();
    b = cmd_cnt;
    push(h0(1)); push(32'd5); push(h2(8'hA0, 0, 0, 0));
    push(32'h4433_2211); push(32'hEEFF_6655);
    settle();
    check("R5 command count", cmd_cnt - b, 7);
    check("R4 addr start", log_start[b & 255], 1);
    check("R4 addr byte", log_byte[b & 255], 8'hA0);
    check("R4 addr not read", log_read[b & 255], 0);
    for (int k = 0; k < 6; k++) begin
      check("R5 data byte", log_byte[(b + 1 + k) & 255], 8'h11 * (k + 1));
      check("R6 stop only last", log_stop[(b + 1 + k) & 255], (k == 5) ? 1 : 0);
      check("R5 no start on data", log_start[(b + 1 + k) & 255], 0);
    end
    check("R5 tx drained", tx_free, 8);
  endtask

  task automatic t_read_r9();
    int b;
    logic [31:0] w;
    do_reset();
    b = cmd_cnt;
    push(h0(1)); push(32'd4); push(h2(8'hA1, 1, 0, 0));
    settle();
    check("R9 command count", cmd_cnt - b, 6);
    for (int k = 1; k <= 5; k++) begin
      check("R8 read dir", log_read[(b + k) & 255], 1);
      check("R8 nack on last only", log_nack[(b + k) & 255], (k == 5) ? 1 : 0);
    end
    check("R6 read stop", log_stop[(b + 5) & 255], 1);
    check("R9 rx_count", rx_count, 2);
    pop_rx(w);
    check("R9 first word", w, {rbyte(b + 4), rbyte(b + 3), rbyte(b + 2), rbyte(b + 1)});
    pop_rx(w);
    check("R9 partial word", w, {24'b0, rbyte(b + 5)});
    check("R9 rx empty", rx_count, 0);
  endtask

  task automatic t_rstart_r6();
    int b;
    do_reset();
    b = cmd_cnt;
    push(h0(1)); push(32'd0); push(h2(8'hA0, 0, 1, 0)); push(32'h0000_0077);
    push(h0(1)); push(32'd1); push(h2(8'hA1, 1, 0, 0));
    settle();
    check("R6 command count", cmd_cnt - b, 5);
    check("R6 no stop before restart", log_stop[(b + 1) & 255], 0);
    check("R6 restart start", log_start[(b + 2) & 255], 1);
    check("R6 restart addr", log_byte[(b + 2) & 255], 8'hA1);
    check("R6 final stop", log_stop[(b + 4) & 255], 1);
    check("R8 final nack", log_nack[(b + 4) & 255], 1);
  endtask

  task automatic t_cont_r7();
    int b, starts, stops;
    do_reset();
    b = cmd_cnt;
    push(h0(1)); push(32'd1); push(h2(8'hA0, 0, 0, 1)); push(32'h0000_BBAA);
    push(h0(1)); push(32'd2); push(h2(8'h55, 0, 0, 0)); push(32'h00EE_DDCC);
    settle();
    check("R7 command count", cmd_cnt - b, 6);
    starts = 0; stops = 0;
    for (int k = 0; k < 6; k++) begin
      starts += int'(log_start[(b + k) & 255]);
      stops  += int'(log_stop[(b + k) & 255]);
    end
    check("R7 single start", starts, 1);
    check("R7 single stop", stops, 1);
    check("R7 payload follows", log_byte[(b + 3) & 255], 8'hCC);
    check("R7 last byte", log_byte[(b + 5) & 255], 8'hEE);
    // read continuation: NACK only at the very end
    do_reset();
    b = cmd_cnt;
    push(h0(1)); push(32'd1); push(h2(8'hA1, 1, 0, 1));
    push(h0(1)); push(32'd1); push(h2(8'hA1, 1, 0, 0));
    settle();
    check("R7 read cont count", cmd_cnt - b, 5);
    check("R8 no nack mid transfer", log_nack[(b + 2) & 255], 0);
    check("R8 nack at end", log_nack[(b + 4) & 255], 1);
    check("R9 one word per packet", rx_count, 2);
  endtask

  task automatic t_proto_r10();
    int b;
    do_reset();
    b = cmd_cnt;
    push(h0(1)); push(32'd0); push(h2(8'hA0, 0, 1, 1)); push(32'h1);
    settle();
    check("R10 err_proto", err_proto, 1);
    check("R10 no command", cmd_cnt - b, 0);
    check("R10 queue emptied", tx_free, 8);
    do_reset();
    b = cmd_cnt;
    push(h0(2)); push(32'd0); push(h2(8'hA0, 0, 0, 0));
    settle();
    check("R3 bad protocol", err_proto, 1);
    check("R3 no command", cmd_cnt - b, 0);
  endtask

  task automatic t_addr_nack_r11();
    int b;
    do_reset();
    b = cmd_cnt;
    nack_at = b;
    push(h0(1)); push(32'd3); push(h2(8'hA0, 0, 0, 0)); push(32'h4433_2211);
    settle();
    nack_at = -1;
    check("R11 err_addr_nack", err_addr_nack, 1);
    check("R11 one command", cmd_cnt - b, 1);
    check("R11 queue emptied", tx_free, 8);
    push(32'h5);
    repeat (2) @(negedge clk);
    check("R11 write dropped", tx_free, 8);
    check("R11 others clear", {err_proto, err_data_nack, err_arb_lost}, 0);
  endtask

  task automatic t_data_nack_r12();
    int b;
    do_reset();
    b = cmd_cnt;
    nack_at = b + 2;
    push(h0(1)); push(32'd3); push(h2(8'hA0, 0, 0, 0)); push(32'h4433_2211);
    settle();
    nack_at = -1;
    check("R12 err_data_nack", err_data_nack, 1);
    check("R12 stopped", cmd_cnt - b, 3);
    check("R12 cmd idle", cmd_valid, 0);
  endtask

  task automatic t_arb_r13();
    int b;
    do_reset();
    b = cmd_cnt;
    arb_at = b + 1;
    push(h0(1)); push(32'd2); push(h2(8'hA1, 1, 0, 0));
    settle();
    arb_at = -1;
    check("R13 err_arb_lost", err_arb_lost, 1);
    check("R13 stopped", cmd_cnt - b, 2);
    check("R13 no rx word", rx_count, 0);
    repeat (10) @(negedge clk);
    check("R13 sticky", err_arb_lost, 1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset_r1();
    t_fill_r2();
    t_write_r4();
    t_read_r9();
    t_rstart_r6();
    t_cont_r7();
    t_proto_r10();
    t_addr_nack_r11();
    t_data_nack_r12();
    t_arb_r13();
    finish_run();
  end
endmodule